// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight status bits of a small 8-bit processor core. From the most significant bit down, these are:

- the global interrupt enable,
- a one-bit transfer store used by bit-copy instructions,
- the half-carry flag,
- the sign flag,
- the two's complement overflow flag,
- the negative flag,
- the zero flag,
- the carry flag.

The ALU reports its results with a per-flag write mask, so each instruction changes only the flags it affects. The block computes the negative and zero flags itself from the ALU result word. The half-carry, overflow and carry flags come straight from the ALU. The sign flag is never stored: it is always formed as negative XOR overflow.

The interrupt controller drives two events into the block. Interrupt entry clears the global enable and interrupt return sets it. The block gates the controller's combined pending request with that enable. The register file uses two bit-transfer paths:
- A bit-store request copies one selected bit of a register value into the transfer bit.
- The bit-load output always presents the supplied register value with the selected bit replaced by the transfer bit.

Software reaches the whole byte through a simple read/write port. The port answers at I/O address 0x3F, or at data-space address 0x5F when the data-space qualifier is set. A direct byte write overrides every other update in the same cycle. Reads are combinational.

Top module: `cpu_status_reg`

## Requirements
- R1: After a synchronous active-low reset, all eight status bits read 0.
- R2: The status byte layout is bit7 I, bit6 T, bit5 H, bit4 S, bit3 V, bit2 N, bit1 Z, bit0 C, and bit4 always equals bit2 XOR bit3, including after a byte write whose bit4 disagrees.
- R3: A bus write with `bus_wr`=1 that hits the register loads the written byte on the next edge, with S recomputed from the new N and V. A hit is address 0x3F with `bus_data_space`=0, or address 0x5F with `bus_data_space`=1. While the address hits, `bus_rdata` shows the status byte.
- R4: A byte write takes priority over interrupt entry, interrupt return, ALU updates and bit-store in the same cycle.
- R5: `irq_taken` clears I on the next edge and `irq_return` sets it. When both are asserted in the same cycle, I is cleared.
- R6: `irq_req` equals `irq_pending` AND I, so it is 0 whenever I is 0.
- R7: The ALU mask is `alu_mask[4:0]`, with bit4 H, bit3 V, bit2 N, bit1 Z and bit0 C. For each mask bit set:
  - H, V and C load `alu_half`, `alu_ovf` and `alu_carry`.
  - N loads the MSB of `alu_result`.
  - Z loads 1 exactly when `alu_result` is zero.

  Flags whose mask bit is clear keep their value.
- R8: When `bst_en` is 1, T loads `reg_val[bit_sel]` on the next edge.
- R9: `bld_value` equals `reg_val` with bit `bit_sel` replaced by T, combinationally.
- R10: A write to a non-matching address, or to a matching address with the wrong space qualifier, leaves the status unchanged, and `bus_rdata` reads 0 when the address does not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 7 | Register bus address |
| bus_data_space | input | 1 | 1: address is in data space (offset 0x20) |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Status byte on hit, else 0 |
| irq_taken | input | 1 | Interrupt entry event |
| irq_return | input | 1 | Interrupt return event |
| irq_pending | input | 1 | Combined request from interrupt sources |
| irq_req | output | 1 | Gated interrupt request |
| alu_mask | input | 5 | Per-flag update mask {H,V,N,Z,C} |
| alu_half | input | 1 | ALU half-carry |
| alu_ovf | input | 1 | ALU overflow |
| alu_carry | input | 1 | ALU carry |
| alu_result | input | 8 | ALU result word |
| bst_en | input | 1 | Bit-store request |
| bit_sel | input | 3 | Selected bit for store and load |
| reg_val | input | 8 | Register-file operand value |
| bld_value | output | 8 | Operand with selected bit replaced by T |
| t_bit | output | 1 | Stored transfer bit |
| status | output | 8 | Full status byte |

## Verification
Same-cycle collisions are the hardest case to reach from the ports. Examples are a byte write together with interrupt entry, an ALU update and a bit-store, or entry and return together. Directed steps build each collision explicitly. A seeded random phase then drives every event line independently, with roughly a third of cycles hitting the register from either address space and some cycles using the wrong space qualifier. In this way, priority and address qualification are exercised against a bench model over many combinations of flag contents.

// File: rtl/csr_pkg.sv
// Package: shared bit positions and the stored-flag record for the status
// register. Assumes the 8-bit layout I,T,H,S,V,N,Z,C from MSB to LSB.
package csr_pkg;
    localparam int unsigned STAT_W   = 8;
    localparam int unsigned MASK_W   = 5;
    localparam int unsigned POS_I    = 7;
    localparam int unsigned POS_T    = 6;
    localparam int unsigned POS_H    = 5;
    localparam int unsigned POS_S    = 4;
    localparam int unsigned POS_V    = 3;
    localparam int unsigned POS_N    = 2;
    localparam int unsigned POS_Z    = 1;
    localparam int unsigned POS_C    = 0;
    // ALU mask bit positions
    localparam int unsigned MSK_H    = 4;
    localparam int unsigned MSK_V    = 3;
    localparam int unsigned MSK_N    = 2;
    localparam int unsigned MSK_Z    = 1;
    localparam int unsigned MSK_C    = 0;

    // Seven flops: the sign flag is never held
    typedef struct packed {
        logic ie;
        logic tb;
        logic hc;
        logic ov;
        logic ng;
        logic zr;
        logic cy;
    } flags_t;

    // Builds the visible byte, forming sign from negative and overflow
    function automatic logic [STAT_W-1:0] to_byte(flags_t f);
        logic [STAT_W-1:0] b;
        b        = '0;
        b[POS_I] = f.ie;
        b[POS_T] = f.tb;
        b[POS_H] = f.hc;
        b[POS_S] = f.ng ^ f.ov;
        b[POS_V] = f.ov;
        b[POS_N] = f.ng;
        b[POS_Z] = f.zr;
        b[POS_C] = f.cy;
        return b;
    endfunction
endpackage

// File: rtl/csr_addr_decode.sv
// Address decoder: flags a bus access that targets the status register,
// either by its I/O address or by its data-space alias. Assumes the alias
// is the I/O address plus a fixed offset and that the qualifier picks the space.
module csr_addr_decode #(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned IO_ADDR     = 'h3F,
    parameter int unsigned DATA_OFFSET = 'h20
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_data_space,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] IO_MATCH   = ADDR_W'(IO_ADDR);
    localparam logic [ADDR_W-1:0] DATA_MATCH = ADDR_W'(IO_ADDR + DATA_OFFSET);

    // Compare against the address of the selected space
    always_comb begin
        if (bus_data_space) hit = (bus_addr == DATA_MATCH);
        else                hit = (bus_addr == IO_MATCH);
    end
endmodule

// File: rtl/csr_bit_xfer.sv
// Bit-transfer path: picks one bit of a register value for a bit-store and
// builds the bit-load result with the selected bit replaced by the transfer
// bit. Purely combinational; assumes bit_sel is in range for DATA_W.
module csr_bit_xfer #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SEL_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] reg_val,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              t_in,
    output logic              picked,
    output logic [DATA_W-1:0] merged
);
    // Select the bit to be copied into the transfer store
    assign picked = reg_val[bit_sel];

    // Replace exactly the selected position with the transfer bit
    for (genvar g = 0; g < DATA_W; g++) begin : g_merge
        assign merged[g] = (bit_sel == SEL_W'(g)) ? t_in : reg_val[g];
    end
endmodule

// File: rtl/csr_flag_core.sv
// Flag storage with update priority: byte write first, then interrupt
// entry/return on I, then masked ALU flags and the bit-store into T.
// Assumes the ALU result and event strobes are valid for one cycle.
module csr_flag_core
    import csr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [STAT_W-1:0] wr_byte,
    input  logic              irq_taken,
    input  logic              irq_return,
    input  logic [MASK_W-1:0] alu_mask,
    input  logic              alu_half,
    input  logic              alu_ovf,
    input  logic              alu_carry,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              bst_en,
    input  logic              bst_bit,
    output flags_t            flags_q
);
    flags_t flags_d;
    logic   res_zero;
    logic   res_neg;
    logic   unused_written_sign;

    assign res_zero            = ~|alu_result;
    assign res_neg             = alu_result[DATA_W-1];
    assign unused_written_sign = wr_byte[POS_S];

    // Next-state selection following the update priority
    always_comb begin
        flags_d = flags_q;
        if (wr_hit) begin
            flags_d.ie = wr_byte[POS_I];
            flags_d.tb = wr_byte[POS_T];
            flags_d.hc = wr_byte[POS_H];
            flags_d.ov = wr_byte[POS_V];
            flags_d.ng = wr_byte[POS_N];
            flags_d.zr = wr_byte[POS_Z];
            flags_d.cy = wr_byte[POS_C];
        end else begin
            if (irq_taken)       flags_d.ie = 1'b0;
            else if (irq_return) flags_d.ie = 1'b1;
            if (alu_mask[MSK_H]) flags_d.hc = alu_half;
            if (alu_mask[MSK_V]) flags_d.ov = alu_ovf;
            if (alu_mask[MSK_N]) flags_d.ng = res_neg;
            if (alu_mask[MSK_Z]) flags_d.zr = res_zero;
            if (alu_mask[MSK_C]) flags_d.cy = alu_carry;
            if (bst_en)          flags_d.tb = bst_bit;
        end
    end

    // Flag register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/cpu_status_reg.sv
// Top of the processor status register: decodes bus accesses, stores the
// flags, derives the sign flag, gates the interrupt request and serves the
// bit-transfer paths. Assumes one-cycle event strobes and a synchronous bus.
module cpu_status_reg
    import csr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned IO_ADDR     = 'h3F,
    parameter int unsigned DATA_OFFSET = 'h20,
    parameter int unsigned DATA_W      = 8,
    localparam int unsigned SEL_W      = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_data_space,
    input  logic              bus_wr,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    input  logic              irq_taken,
    input  logic              irq_return,
    input  logic              irq_pending,
    output logic              irq_req,
    input  logic [MASK_W-1:0] alu_mask,
    input  logic              alu_half,
    input  logic              alu_ovf,
    input  logic              alu_carry,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              bst_en,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] bld_value,
    output logic              t_bit,
    output logic [STAT_W-1:0] status
);
    logic   addr_hit;
    logic   wr_hit;
    logic   picked;
    flags_t flags_q;

    csr_addr_decode #(
        .ADDR_W(ADDR_W), .IO_ADDR(IO_ADDR), .DATA_OFFSET(DATA_OFFSET)
    ) u_dec (
        .bus_addr(bus_addr), .bus_data_space(bus_data_space), .hit(addr_hit)
    );

    csr_bit_xfer #(.DATA_W(DATA_W)) u_xfer (
        .reg_val(reg_val), .bit_sel(bit_sel), .t_in(flags_q.tb),
        .picked(picked), .merged(bld_value)
    );

    csr_flag_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_byte(bus_wdata),
        .irq_taken(irq_taken), .irq_return(irq_return),
        .alu_mask(alu_mask), .alu_half(alu_half), .alu_ovf(alu_ovf),
        .alu_carry(alu_carry), .alu_result(alu_result),
        .bst_en(bst_en), .bst_bit(picked), .flags_q(flags_q)
    );

    // Qualify the write strobe with the address match
    assign wr_hit    = bus_wr & addr_hit;
    // Present the full byte, sign formed on the fly
    assign status    = to_byte(flags_q);
    // Read returns the byte only while the address matches
    assign bus_rdata = addr_hit ? status : '0;
    // Global enable gates the combined request
    assign irq_req   = irq_pending & flags_q.ie;
    assign t_bit     = flags_q.tb;
endmodule

// File: rtl/csr_checker.sv
// Checker: port-level properties of the status register, bound to the top.
module csr_checker #(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned IO_ADDR     = 'h3F,
    parameter int unsigned DATA_OFFSET = 'h20,
    parameter int unsigned DATA_W      = 8,
    localparam int unsigned SEL_W      = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_data_space,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              irq_taken,
    input logic              irq_return,
    input logic              irq_pending,
    input logic              irq_req,
    input logic [4:0]        alu_mask,
    input logic              bst_en,
    input logic [SEL_W-1:0]  bit_sel,
    input logic [DATA_W-1:0] reg_val,
    input logic [7:0]        status
);
    logic wr_match;
    assign wr_match = bus_wr &&
        ((!bus_data_space && bus_addr == ADDR_W'(IO_ADDR)) ||
         ( bus_data_space && bus_addr == ADDR_W'(IO_ADDR + DATA_OFFSET)));

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> status == 8'h00); // R1
    AST_SIGN_IS_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] == (status[2] ^ status[3])); // R2
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_match |=> status == {$past(bus_wdata[7:5]),
            $past(bus_wdata[2]) ^ $past(bus_wdata[3]), $past(bus_wdata[3:0])}); // R4
    AST_ENTRY_CLEARS_I: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_taken && !wr_match) |=> !status[7]); // R5
    AST_RETURN_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_taken && !wr_match) |=> status[7]); // R5
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !status[7] |-> !irq_req); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_match && !irq_taken && !irq_return && alu_mask == 5'd0 && !bst_en)
        |=> $stable(status)); // R10
    AST_STORE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_en && !wr_match) |=> status[6] == $past(reg_val[bit_sel])); // R8
endmodule

bind cpu_status_reg csr_checker #(
    .ADDR_W(ADDR_W), .IO_ADDR(IO_ADDR), .DATA_OFFSET(DATA_OFFSET), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/cpu_status_reg_tb_top.sv
// Bench: directed corner cases then seeded random stimulus against a model.
module cpu_status_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] bus_addr;
    logic       bus_data_space, bus_wr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       irq_taken, irq_return, irq_pending, irq_req;
    logic [4:0] alu_mask;
    logic       alu_half, alu_ovf, alu_carry;
    logic [7:0] alu_result;
    logic       bst_en;
    logic [2:0] bit_sel;
    logic [7:0] reg_val, bld_value, status;
    logic       t_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cpu_status_reg dut_i (.*);

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic bit is_hit(logic [6:0] a, logic ds);
        return ds ? (a == 7'h5F) : (a == 7'h3F);
    endfunction

    // Expected next status from the requirements
    function automatic logic [7:0] model_next(logic [7:0] cur);
        logic [7:0] n;
        if (bus_wr && is_hit(bus_addr, bus_data_space)) begin
            n = bus_wdata;
        end else begin
            n = cur;
            if (irq_taken)       n[7] = 1'b0;
            else if (irq_return) n[7] = 1'b1;
            if (alu_mask[4]) n[5] = alu_half;
            if (alu_mask[3]) n[3] = alu_ovf;
            if (alu_mask[2]) n[2] = alu_result[7];
            if (alu_mask[1]) n[1] = (alu_result == 8'h00);
            if (alu_mask[0]) n[0] = alu_carry;
            if (bst_en)      n[6] = reg_val[bit_sel];
        end
        n[4] = n[2] ^ n[3];
        return n;
    endfunction

    function automatic logic [7:0] model_bld(logic [7:0] v, logic [2:0] s, logic t);
        logic [7:0] r;
        r = v;
        r[s] = t;
        return r;
    endfunction

    task automatic idle();
        bus_addr = 7'h00; bus_data_space = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
        irq_taken = 1'b0; irq_return = 1'b0; irq_pending = 1'b0;
        alu_mask = '0; alu_half = 1'b0; alu_ovf = 1'b0; alu_carry = 1'b0;
        alu_result = 8'h00; bst_en = 1'b0; bit_sel = 3'd0; reg_val = 8'h00;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(logic [6:0] a, logic ds, logic [7:0] d);
        idle();
        bus_addr = a; bus_data_space = ds; bus_wr = 1'b1; bus_wdata = d;
        tick();
        idle();
    endtask

    initial begin : watchdog
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] exp;
        void'($urandom(32'h5EED_2024));
        idle();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        chk("R1 reset status", status, 8'h00);
        irq_pending = 1'b1; #1;
        chk("R6 req gated after reset", {7'd0, irq_req}, 8'h00);
        idle();

        bus_write(7'h3F, 1'b0, 8'hFF);
        chk("R2 S from N^V on write", status, 8'hEF);
        bus_addr = 7'h3F; #1;
        chk("R3 read at io address", bus_rdata, 8'hEF);
        idle();
        bus_write(7'h3F, 1'b0, 8'h10);
        chk("R2 written S ignored", status, 8'h00);
        bus_write(7'h5F, 1'b1, 8'h84);
        chk("R3 write via data space", status, 8'h94);
        bus_write(7'h3F, 1'b1, 8'h01);
        chk("R10 wrong space no write", status, 8'h94);
        bus_write(7'h12, 1'b0, 8'h01);
        chk("R10 other address no write", status, 8'h94);
        bus_addr = 7'h5F; bus_data_space = 1'b0; #1;
        chk("R10 read miss is zero", bus_rdata, 8'h00);
        idle(); irq_pending = 1'b1; #1;
        chk("R6 req passes with I set", {7'd0, irq_req}, 8'h01);

        idle(); irq_taken = 1'b1; tick(); idle();
        chk("R5 entry clears I", status, 8'h14);
        irq_pending = 1'b1; #1;
        chk("R6 req blocked with I clear", {7'd0, irq_req}, 8'h00);
        idle(); irq_return = 1'b1; tick(); idle();
        chk("R5 return sets I", status, 8'h94);
        irq_taken = 1'b1; irq_return = 1'b1; tick(); idle();
        chk("R5 entry wins over return", status, 8'h14);

        bus_addr = 7'h3F; bus_wr = 1'b1; bus_wdata = 8'h80;
        irq_taken = 1'b1; alu_mask = 5'h1F; alu_carry = 1'b1; alu_result = 8'h00;
        bst_en = 1'b1; reg_val = 8'hFF;
        tick(); idle();
        chk("R4 write beats other updates", status, 8'h80);

        alu_mask = 5'b00010; alu_result = 8'h00; alu_carry = 1'b1; tick(); idle();
        chk("R7 Z only from zero result", status, 8'h82);
        alu_mask = 5'b00110; alu_result = 8'h80; tick(); idle();
        chk("R7 N and Z from negative result", status, 8'h94);
        alu_mask = 5'b11001; alu_half = 1'b1; alu_ovf = 1'b1; alu_carry = 1'b1;
        tick(); idle();
        chk("R7 H V C loaded, S follows", status, 8'hAD);

        bst_en = 1'b1; bit_sel = 3'd5; reg_val = 8'h20; tick(); idle();
        chk("R8 store copies selected bit", {7'd0, t_bit}, 8'h01);
        reg_val = 8'h00; bit_sel = 3'd3; #1;
        chk("R9 load inserts T", bld_value, 8'h08);
        reg_val = 8'hFF; bit_sel = 3'd0; #1;
        chk("R9 load keeps other bits", bld_value, 8'hFF);
        idle();

        for (int i = 0; i < 3000; i++) begin
            int pick;
            pick = $urandom_range(0, 5);
            bus_wr = ($urandom_range(0, 2) == 0);
            case (pick)
                0: begin bus_addr = 7'h3F; bus_data_space = 1'b0; end
                1: begin bus_addr = 7'h5F; bus_data_space = 1'b1; end
                2: begin bus_addr = 7'h3F; bus_data_space = 1'b1; end
                3: begin bus_addr = 7'h5F; bus_data_space = 1'b0; end
                default: begin bus_addr = 7'($urandom); bus_data_space = 1'($urandom); end
            endcase
            bus_wdata   = 8'($urandom);
            irq_taken   = ($urandom_range(0, 4) == 0);
            irq_return  = ($urandom_range(0, 3) == 0);
            irq_pending = 1'($urandom);
            alu_mask    = 5'($urandom);
            alu_half    = 1'($urandom);
            alu_ovf     = 1'($urandom);
            alu_carry   = 1'($urandom);
            alu_result  = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
            bst_en      = 1'($urandom);
            bit_sel     = 3'($urandom);
            reg_val     = 8'($urandom);
            #1;
            chk("R9 random load", bld_value, model_bld(reg_val, bit_sel, status[6]));
            chk("R6 random gate", {7'd0, irq_req}, {7'd0, irq_pending & status[7]});
            chk("R3 random read", bus_rdata,
                is_hit(bus_addr, bus_data_space) ? status : 8'h00);
            exp = model_next(status);
            tick();
            chk("R7 R4 random update", status, exp);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule